// File: doc/BRIEF.md
# Serial PCM Codec Control Port

This block is the digital side of a telephony filter/codec: the serial data port and the control registers. It runs from a 2.048 MHz bit clock with a 256-clock frame. An active-low frame strobe opens an eight-clock channel slot. In each slot the block does three things:

- shifts an encoder byte out, MSB first, on a three-state line (modelled as data plus output enable);
- shifts a received PCM byte in;
- optionally shifts in an eight-bit control word.

A three-level address input, coded as two bits, selects where the control word lands and whether PCM moves in that slot.

Control register A holds the transmit gain, the receive gain and the operating mode (normal, digital loopback, analog loopback, powerdown). Control register B holds a test-mode selector and six general-purpose drive outputs. A static-mode input marks the control pin as carrying a fixed level rather than a serial word. With the address at its low level, that fixed level selects plain operation or powerdown. After reset the registers hold the powerdown state and ignore writes for a fixed number of clocks.

The decoded byte goes to an external decoder model with a one-cycle valid pulse after the eighth received bit. The byte to send is taken from an external encoder model at the start of the slot.

Top module: `pcm_ctrl_port`

## Requirements
- R1: The frame strobe is sampled on rising edges. The slot starts on the first rising edge that sees the strobe low after it was high. On that edge the block samples enc_byte, raises pcm_oe and drives bit 7 on pcm_out. Bits 6 down to 0 follow on the next seven rising edges. pcm_oe is high for exactly 8 clocks, and pcm_out is 0 whenever pcm_oe is low.
- R2: pcm_in and ctl_in are captured on the falling edges inside the slot, first bit as bit 7. On the rising edge that ends the slot, dec_byte takes the received PCM byte and dec_valid is high for exactly one cycle.
- R3: Input bits outside a slot are ignored: dec_valid stays low, and dec_byte and both registers keep their values.
- R4: ctl_addr encoding is 00 = low level, 01 = middle level, 1x = high level. A serial word with ctl_addr 01 loads register A and leaves register B unchanged.
- R5: A serial word with ctl_addr 00 loads register A and clears register B to zero, so drive and test_mode go to 0.
- R6: A serial word with ctl_addr 1x loads register B and leaves register A unchanged. In that slot pcm_oe stays low and no dec_valid pulse is produced.
- R7: With ctl_static = 1 and ctl_addr = 00, a low level on ctl_in sets register A to zero (normal mode, both gains 0). A high level sets the powerdown mode.
- R8: Register A decode: bits 2:0 drive tx_gain (0..7 dB boost), bits 5:3 drive rx_gain (0..7 dB cut), and bits 7:6 select the mode: 00 normal, 01 digital loopback (dig_loop), 10 analog loopback (ana_loop), 11 powerdown (pdown).
- R9: In powerdown, pcm_oe stays low through a slot and no dec_valid pulse occurs, but control words are still accepted.
- R10: In digital loopback, the byte sent in a slot is the PCM byte received in the previous PCM slot, and dec_byte is reported as zero.
- R11: Reset puts register A in powerdown (pdown = 1, gains 0) and register B at zero. For 25 clocks after reset release, every control write is ignored.
- R12: Register B decode: bits 7:6 drive test_mode and bits 5:0 drive drive[5:0], bit 0 to drive[0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 2.048 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame/slot strobe |
| ctl_addr | input | 2 | Control address level: 00 low, 01 middle, 1x high |
| ctl_static | input | 1 | 1 = ctl_in carries a static level, 0 = serial word |
| ctl_in | input | 1 | Serial control word or static control level |
| pcm_in | input | 1 | Serial received PCM data |
| pcm_out | output | 1 | Serial transmitted PCM data |
| pcm_oe | output | 1 | Output enable for pcm_out (low = high impedance) |
| enc_byte | input | 8 | Byte from the encoder, sampled at slot start |
| dec_byte | output | 8 | Byte to the decoder |
| dec_valid | output | 1 | One-cycle strobe marking a new dec_byte |
| tx_gain | output | 3 | Transmit gain step in dB |
| rx_gain | output | 3 | Receive attenuation step in dB |
| dig_loop | output | 1 | Digital loopback active |
| ana_loop | output | 1 | Analog loopback active |
| pdown | output | 1 | Powerdown active |
| test_mode | output | 2 | Test-mode selector from register B |
| drive | output | 6 | General-purpose drive outputs from register B |

## Verification
Slots are run with each address level. The middle level and the low level both load register A but differ in whether register B survives, and the high level differs from both by suppressing PCM traffic and targeting register B. Distinct byte values are used in and out (A5, 3C, 96, 5A), so a swapped bit order, a bit slip or a stale byte shows in the comparison. The digital-loopback patterns run three consecutive slots so the one-slot delay from received byte to transmitted byte is visible. Static-level patterns, writes inside the post-reset window and a slot in powerdown separate the cases where control is accepted from those where it must be dropped.

// File: rtl/pcm_ctrl_pkg.sv
package pcm_ctrl_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ADDR_LOW  = 2'b00,
    ADDR_MID  = 2'b01,
    ADDR_HIGH = 2'b10,
    ADDR_HI2  = 2'b11
  } addr_lvl_e;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_DIGLOOP = 2'b01,
    MODE_ANALOOP = 2'b10,
    MODE_PDOWN   = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [2:0] rxg;
    logic [2:0] txg;
  } cfg_a_t;

  typedef struct packed {
    logic [1:0] test;
    logic [5:0] drv;
  } cfg_b_t;

  localparam cfg_a_t CFG_A_PDOWN = '{mode: MODE_PDOWN, rxg: 3'd0, txg: 3'd0};
  localparam cfg_a_t CFG_A_IDLE  = '{mode: MODE_NORMAL, rxg: 3'd0, txg: 3'd0};

endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer #(
  parameter int WORD_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  output logic active,
  output logic start,
  output logic last
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic             frame_q;
  logic             active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a slot opens only on a high-to-low strobe transition seen on rising edges
  assign start = frame_q & ~frame_n & ~active;
  assign last  = active & (cnt_q == CNT_LAST);

  always_comb begin
    active_d = active;
    cnt_d    = cnt_q;
    if (start) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (last) begin
      active_d = 1'b0;
    end else if (active) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      active  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      frame_q <= frame_n;
      active  <= active_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int WORD_W = 8,
  parameter int LANES  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [LANES-1:0]             din,
  output logic [LANES-1:0][WORD_W-1:0] word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] sh_q, sh_d;

    always_comb begin
      sh_d = sh_q;
      if (en) begin
        sh_d = {sh_q[WORD_W-2:0], din[g]};
      end
    end

    // capture on the falling edge, midway through each driven bit
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign word[g] = sh_q;
  end

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] load_val,
  output logic              bit_out
);

  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign bit_out = sh_q[WORD_W-1];

endmodule

// File: rtl/pcm_ctrl_regs.sv
module pcm_ctrl_regs
  import pcm_ctrl_pkg::*;
#(
  parameter int LOCK_CYC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              commit,
  input  addr_lvl_e         addr,
  input  logic              ctl_static,
  input  logic              ctl_lvl,
  input  logic [BYTE_W-1:0] ctl_word,
  output cfg_a_t            reg_a,
  output cfg_b_t            reg_b,
  output addr_lvl_e         addr_q
);

  localparam int LK_W = $clog2(LOCK_CYC + 1);
  localparam logic [LK_W-1:0] LK_INIT = LK_W'(LOCK_CYC);

  logic [LK_W-1:0] lock_q, lock_d;
  logic            locked;
  logic            stat_q, stat_d;
  addr_lvl_e       addr_d;
  cfg_a_t          a_d;
  cfg_b_t          b_d;

  logic ser_ok, to_b, wr_a, wr_b, clr_b, stat_wr;

  assign locked  = (lock_q != '0);
  assign ser_ok  = commit & ~locked & ~stat_q;
  assign to_b    = addr_q[1];
  assign wr_a    = ser_ok & ~to_b;
  assign wr_b    = ser_ok & to_b;
  assign clr_b   = ser_ok & (addr_q == ADDR_LOW);
  assign stat_wr = ~locked & ctl_static & (addr == ADDR_LOW) & ~commit;

  always_comb begin
    lock_d = lock_q;
    if (locked) begin
      lock_d = lock_q - 1'b1;
    end
    addr_d = addr_q;
    stat_d = stat_q;
    if (start) begin
      addr_d = addr;
      stat_d = ctl_static;
    end
    a_d = reg_a;
    if (wr_a) begin
      a_d = cfg_a_t'(ctl_word);
    end else if (stat_wr) begin
      a_d = ctl_lvl ? CFG_A_PDOWN : CFG_A_IDLE;
    end
    b_d = reg_b;
    // gated synchronous clear takes precedence over a load
    if (clr_b) begin
      b_d = '0;
    end else if (wr_b) begin
      b_d = cfg_b_t'(ctl_word);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= LK_INIT;
      addr_q <= ADDR_MID;
      stat_q <= 1'b0;
      reg_a  <= CFG_A_PDOWN;
      reg_b  <= '0;
    end else begin
      lock_q <= lock_d;
      addr_q <= addr_d;
      stat_q <= stat_d;
      reg_a  <= a_d;
      reg_b  <= b_d;
    end
  end

endmodule

// File: rtl/pcm_ctrl_port.sv
module pcm_ctrl_port
  import pcm_ctrl_pkg::*;
#(
  parameter int LOCK_CYC  = 25,
  parameter int RST_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic [1:0] ctl_addr,
  input  logic       ctl_static,
  input  logic       ctl_in,
  input  logic       pcm_in,
  output logic       pcm_out,
  output logic       pcm_oe,
  input  logic [7:0] enc_byte,
  output logic [7:0] dec_byte,
  output logic       dec_valid,
  output logic [2:0] tx_gain,
  output logic [2:0] rx_gain,
  output logic       dig_loop,
  output logic       ana_loop,
  output logic       pdown,
  output logic [1:0] test_mode,
  output logic [5:0] drive
);

  localparam int LANE_PCM = 0;
  localparam int LANE_CTL = 1;
  localparam int N_LANES  = 2;

  logic                               rst_i_n;
  logic                               active, start, last;
  logic [N_LANES-1:0][BYTE_W-1:0]     rx_words;
  logic                               tx_bit;
  cfg_a_t                             reg_a;
  cfg_b_t                             reg_b;
  addr_lvl_e                          addr_q;
  logic                               pcm_en;
  logic                               take;
  logic [BYTE_W-1:0]                  hold_q, hold_d;
  logic [BYTE_W-1:0]                  dec_d;
  logic                               dec_v_d;
  logic [BYTE_W-1:0]                  tx_src;

  pcm_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pcm_slot_timer #(.WORD_W(BYTE_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .frame_n (frame_n),
    .active  (active),
    .start   (start),
    .last    (last)
  );

  pcm_rx_shift #(.WORD_W(BYTE_W), .LANES(N_LANES)) u_rx (
    .clk   (clk),
    .rst_n (rst_i_n),
    .en    (active),
    .din   ({ctl_in, pcm_in}),
    .word  (rx_words)
  );

  pcm_ctrl_regs #(.LOCK_CYC(LOCK_CYC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .start      (start),
    .commit     (last),
    .addr       (addr_lvl_e'(ctl_addr)),
    .ctl_static (ctl_static),
    .ctl_lvl    (ctl_in),
    .ctl_word   (rx_words[LANE_CTL]),
    .reg_a      (reg_a),
    .reg_b      (reg_b),
    .addr_q     (addr_q)
  );

  // mode and field decode
  assign tx_gain   = reg_a.txg;
  assign rx_gain   = reg_a.rxg;
  assign dig_loop  = (reg_a.mode == MODE_DIGLOOP);
  assign ana_loop  = (reg_a.mode == MODE_ANALOOP);
  assign pdown     = (reg_a.mode == MODE_PDOWN);
  assign test_mode = reg_b.test;
  assign drive     = reg_b.drv;

  // PCM moves only in slots addressed below the high level
  assign pcm_en = ~addr_q[1];
  assign tx_src = dig_loop ? hold_q : enc_byte;

  pcm_tx_shift #(.WORD_W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (start),
    .shift    (active),
    .load_val (tx_src),
    .bit_out  (tx_bit)
  );

  assign pcm_oe  = active & pcm_en & ~pdown;
  assign pcm_out = pcm_oe & tx_bit;

  assign take = last & pcm_en & ~pdown;

  always_comb begin
    hold_d  = hold_q;
    dec_d   = dec_byte;
    dec_v_d = 1'b0;
    if (take) begin
      hold_d  = rx_words[LANE_PCM];
      dec_d   = dig_loop ? '0 : rx_words[LANE_PCM];
      dec_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      hold_q    <= '0;
      dec_byte  <= '0;
      dec_valid <= 1'b0;
    end else begin
      hold_q    <= hold_d;
      dec_byte  <= dec_d;
      dec_valid <= dec_v_d;
    end
  end

endmodule

// File: rtl/pcm_ctrl_port_chk.sv
module pcm_ctrl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pcm_oe,
  input logic       pcm_out,
  input logic       dec_valid,
  input logic [7:0] dec_byte,
  input logic       pdown,
  input logic       dig_loop
);

  localparam int SLOT_LEN = 8;

  logic [4:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run <= '0;
    end else if (pcm_oe) begin
      oe_run <= (oe_run == 5'd31) ? oe_run : oe_run + 1'b1;
    end else begin
      oe_run <= '0;
    end
  end

  // R1
  slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_run <= 5'(SLOT_LEN));

  // R1
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_oe |-> !pcm_out);

  // R2
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R9
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> !pdown);

  // R9
  pd_nodec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !$past(pdown));

  // R10
  loop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && $past(dig_loop)) |-> (dec_byte == 8'h00));

endmodule

bind pcm_ctrl_port pcm_ctrl_port_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pcm_oe    (pcm_oe),
  .pcm_out   (pcm_out),
  .dec_valid (dec_valid),
  .dec_byte  (dec_byte),
  .pdown     (pdown),
  .dig_loop  (dig_loop)
);

// File: tb/tb_pcm_ctrl_port.sv
`timescale 1ns/1ps
module tb_pcm_ctrl_port;

  logic       clk;
  logic       rst_n;
  logic       frame_n;
  logic [1:0] ctl_addr;
  logic       ctl_static;
  logic       ctl_in;
  logic       pcm_in;
  logic       pcm_out;
  logic       pcm_oe;
  logic [7:0] enc_byte;
  logic [7:0] dec_byte;
  logic       dec_valid;
  logic [2:0] tx_gain;
  logic [2:0] rx_gain;
  logic       dig_loop;
  logic       ana_loop;
  logic       pdown;
  logic [1:0] test_mode;
  logic [5:0] drive;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  pcm_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ctl_addr(ctl_addr),
    .ctl_static(ctl_static), .ctl_in(ctl_in), .pcm_in(pcm_in),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .enc_byte(enc_byte),
    .dec_byte(dec_byte), .dec_valid(dec_valid), .tx_gain(tx_gain),
    .rx_gain(rx_gain), .dig_loop(dig_loop), .ana_loop(ana_loop),
    .pdown(pdown), .test_mode(test_mode), .drive(drive)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // One slot: returns 2 ns after the rising edge that closes it.
  task automatic run_slot(input logic [1:0] a, input logic [7:0] pcm_d,
                          input logic [7:0] ctl_d, input logic [7:0] exp_out,
                          input bit exp_oe, input string rq);
    @(posedge clk); #1;
    frame_n = 1'b0; ctl_addr = a; pcm_in = pcm_d[7]; ctl_in = ctl_d[7];
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      check(rq, $sformatf("oe bit %0d", i), pcm_oe, exp_oe);
      if (exp_oe) check(rq, $sformatf("out bit %0d", 7 - i), pcm_out, exp_out[7 - i]);
      pcm_in = pcm_d[7 - i];
      ctl_in = ctl_d[7 - i];
      if (i == 7) frame_n = 1'b1;
    end
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    check("R11", "pdown after reset", pdown, 1'b1);
    check("R11", "tx_gain after reset", tx_gain, 3'd0);
    check("R11", "drive after reset", drive, 6'd0);
    check("R12", "test_mode after reset", test_mode, 2'd0);
    check("R1", "oe idle", pcm_oe, 1'b0);
    check("R2", "dec_valid idle", dec_valid, 1'b0);
  endtask

  task automatic t_lockout();
    // serial write of an all-zero A word while the window is open
    run_slot(2'b01, 8'h3C, 8'h00, 8'h00, 1'b0, "R9");
    check("R11", "write ignored in lockout", pdown, 1'b1);
    check("R9", "no dec_valid in powerdown", dec_valid, 1'b0);
  endtask

  task automatic t_static();
    ctl_static = 1'b1; ctl_addr = 2'b00; ctl_in = 1'b0;
    idle(2);
    check("R7", "static low pdown", pdown, 1'b0);
    check("R7", "static low gains", {rx_gain, tx_gain}, 6'd0);
    ctl_in = 1'b1;
    idle(2);
    check("R7", "static high pdown", pdown, 1'b1);
    run_slot(2'b00, 8'h77, 8'hFF, 8'h00, 1'b0, "R9");
    check("R9", "no dec_valid static pd", dec_valid, 1'b0);
    ctl_in = 1'b0;
    idle(2);
    check("R7", "static low again", pdown, 1'b0);
    ctl_static = 1'b0;
  endtask

  task automatic t_write_a_mid();
    enc_byte = 8'hA5;
    run_slot(2'b01, 8'h3C, 8'h2B, 8'hA5, 1'b1, "R1");
    check("R2", "dec_valid pulse", dec_valid, 1'b1);
    check("R2", "dec_byte", dec_byte, 8'h3C);
    check("R8", "tx_gain", tx_gain, 3'd3);
    check("R8", "rx_gain", rx_gain, 3'd5);
    check("R8", "normal mode", {pdown, ana_loop, dig_loop}, 3'b000);
    check("R1", "oe after slot", pcm_oe, 1'b0);
    @(posedge clk); #2;
    check("R2", "dec_valid one cycle", dec_valid, 1'b0);
  endtask

  task automatic t_ignore_outside();
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      pcm_in = i[0]; ctl_in = ~i[0];
      check("R3", "no dec_valid outside slot", dec_valid, 1'b0);
    end
    idle(1);
    check("R3", "dec_byte kept", dec_byte, 8'h3C);
    check("R3", "reg A kept", {rx_gain, tx_gain}, {3'd5, 3'd3});
  endtask

  task automatic t_write_b_high();
    run_slot(2'b10, 8'hFF, 8'hB5, 8'h00, 1'b0, "R6");
    check("R6", "no dec_valid", dec_valid, 1'b0);
    check("R12", "test_mode", test_mode, 2'd2);
    check("R12", "drive", drive, 6'h35);
    check("R6", "reg A kept", {rx_gain, tx_gain}, {3'd5, 3'd3});
    check("R6", "dec_byte kept", dec_byte, 8'h3C);
  endtask

  task automatic t_mid_keeps_b();
    run_slot(2'b01, 8'h81, 8'h80, 8'hA5, 1'b1, "R4");
    check("R8", "analog loop", ana_loop, 1'b1);
    check("R4", "tx_gain new", tx_gain, 3'd0);
    check("R4", "drive kept", drive, 6'h35);
    check("R4", "test kept", test_mode, 2'd2);
  endtask

  task automatic t_low_clears_b();
    run_slot(2'b00, 8'h42, 8'h11, 8'hA5, 1'b1, "R5");
    check("R5", "drive cleared", drive, 6'd0);
    check("R5", "test cleared", test_mode, 2'd0);
    check("R5", "A loaded", {rx_gain, tx_gain}, {3'd2, 3'd1});
    check("R5", "dec_byte", dec_byte, 8'h42);
  endtask

  task automatic t_digloop();
    enc_byte = 8'hFF;
    run_slot(2'b01, 8'h96, 8'h40, 8'hFF, 1'b1, "R10");
    check("R8", "dig_loop set", dig_loop, 1'b1);
    check("R10", "last normal dec", dec_byte, 8'h96);
    run_slot(2'b01, 8'h5A, 8'h40, 8'h96, 1'b1, "R10");
    check("R10", "loop dec valid", dec_valid, 1'b1);
    check("R10", "loop dec zero", dec_byte, 8'h00);
    run_slot(2'b01, 8'h00, 8'h00, 8'h5A, 1'b1, "R10");
    check("R10", "loop left", dig_loop, 1'b0);
  endtask

  task automatic t_pd_serial();
    run_slot(2'b01, 8'h11, 8'hC0, 8'hFF, 1'b1, "R8");
    check("R8", "pdown via word", pdown, 1'b1);
    run_slot(2'b01, 8'h22, 8'h00, 8'h00, 1'b0, "R9");
    check("R9", "no dec_valid", dec_valid, 1'b0);
    check("R9", "write accepted in pd", pdown, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; ctl_addr = 2'b01; ctl_static = 1'b0;
    ctl_in = 1'b0; pcm_in = 1'b0; enc_byte = 8'h00;
    idle(4);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_lockout();
    idle(30);
    t_static();
    t_write_a_mid();
    t_ignore_outside();
    t_write_b_high();
    t_mid_keeps_b();
    t_low_clears_b();
    t_digloop();
    t_pd_serial();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule